// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block sits beside a one-to-many I2C switch and watches the shared downstream clock and data node. While at least one downstream channel is switched in, a timer counts how long it has been since the clock and data lines were last both high in the same cycle. If that span reaches a limit, the bus is taken to be stuck. The block then pulls an active-low fault flag.

What happens next depends on a strap input. With the strap low, the block only flags the fault and drops the flag again once the bus goes idle. With the strap high, the block also asks the switch to cut the upstream side off. After a settling wait it drives slow clock pulses on the downstream clock line. It stops as soon as the bus reads idle, or after a maximum count, whichever comes first. A STOP condition always follows the clocking. While the block is clocking and sending the STOP, it keeps the rise-time accelerators inhibited.

Once the STOP has been sent and the bus is idle, the fault flag is released. The disconnect request stays on until the connection controller reports that the channel enables have gone through a fresh re-enable sequence. The clock and data outputs are pull-down enables: a one means drive the line low.

Top module: `i2c_stuck_recovery`

## Requirements
- R1: The downstream lines pass through a two-stage synchronizer. While a channel is active and the lines are not both high, `fault_n` falls exactly TIMEOUT_CYC+2 clock cycles after the lines stop being both high at the ports.
- R2: A single cycle in which both lines are high at the ports restarts the timeout from zero.
- R3: While `chan_active` is low the timeout does not advance. Once `chan_active` rises with the bus still low, `fault_n` falls exactly TIMEOUT_CYC cycles later.
- R4: With `disc_en` low, a timeout asserts only `fault_n`. `disconnect`, `scl_pull` and `sda_pull` stay 0. `fault_n` returns to 1 within 4 cycles of both lines going high.
- R5: With `disc_en` high, `disconnect` rises in the same cycle as the fault. The first recovery clock pull (`scl_pull`=1) begins exactly WAIT_CYC cycles later.
- R6: Each recovery clock pulls SCL low for HALF_CYC cycles and then releases it for HALF_CYC cycles, with `sda_pull`=0. Clocking ends after MAX_PULSES pulses, or earlier at the end of the first released half in which both synchronized lines are high.
- R7: After clocking, a STOP is made: SDA and SCL are pulled together, then SCL is released while SDA is held, then SDA is released while SCL is not pulled.
- R8: `accel_inhibit` is 1 in every cycle in which `scl_pull` or `sda_pull` is 1, from the first recovery clock through the end of the STOP.
- R9: After the STOP, `fault_n` returns to 1 once both lines are high. `disconnect` stays 1 until `reenable_seen` is seen high and falls on the next cycle.
- R10: After reset, `fault_n`=1 and `disconnect`, `scl_pull`, `sda_pull` and `accel_inhibit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled level of the downstream clock node |
| sda_in | input | 1 | Sampled level of the downstream data node |
| disc_en | input | 1 | Strap: 1 enables disconnect and recovery clocking |
| chan_active | input | 1 | 1 when at least one downstream channel is switched in |
| reenable_seen | input | 1 | Pulse from the connection controller after a fresh re-enable sequence |
| fault_n | output | 1 | Active-low stuck-bus fault flag |
| disconnect | output | 1 | Request to isolate the upstream side |
| scl_pull | output | 1 | 1 = pull downstream SCL low |
| sda_pull | output | 1 | 1 = pull downstream SDA low |
| accel_inhibit | output | 1 | 1 = keep rise-time accelerators off |

## Verification
A timer that is off by a count shows at the ports as a fault edge one cycle early or late, so fault latency is measured to the exact cycle. A sequencer state or pulse counter that is wrong shows within one half-period. It appears as a pull of the wrong length, an extra or missing clock pulse compared with the point where the simulated device let go, or an SDA release while SCL is still pulled. A wrong hold state shows only when the bus is idle, as a `disconnect` that drops before, or stays up after, the re-enable pulse.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FLAG,
    ST_WAIT,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STP_LO,
    ST_STP_SH,
    ST_STP_REL,
    ST_SETTLE,
    ST_HOLD
  } rcv_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2c_rcv_sync.sv
module i2c_rcv_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // Lines idle high, so both stages reset to one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/i2c_rcv_timer.sv
module i2c_rcv_timer #(
  parameter int unsigned TIMEOUT_CYC = 45000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic chan_active,
  input  logic bus_high,
  output logic expired
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run;
  logic          cnt_en;

  assign run     = arm && chan_active && !bus_high;
  assign expired = run && (cnt_q == CW'(TIMEOUT_CYC - 1));
  assign cnt_en  = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || expired) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: no active channel keeps the timer at zero
  a_r3_timer_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |=> (cnt_q == '0));

  // R1: an expiry is a single-cycle event
  a_r1_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);

endmodule

// File: rtl/i2c_rcv_seq.sv
module i2c_rcv_seq
  import i2c_rcv_pkg::*;
#(
  parameter int unsigned WAIT_CYC   = 40,
  parameter int unsigned HALF_CYC   = 91,
  parameter int unsigned MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expired,
  input  logic bus_high,
  input  logic disc_en,
  input  logic reenable_seen,
  output logic idle,
  output logic fault_n,
  output logic disconnect,
  output logic scl_pull,
  output logic sda_pull,
  output logic accel_inhibit
);

  localparam int unsigned TW = $clog2(max2(WAIT_CYC, HALF_CYC) + 1);
  localparam int unsigned PW = $clog2(MAX_PULSES + 1);

  rcv_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] pls_q, pls_d;
  logic          half_done, wait_done;

  assign half_done = (tmr_q == TW'(HALF_CYC - 1));
  assign wait_done = (tmr_q == TW'(WAIT_CYC - 1));

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q + 1'b1;
    pls_d = pls_q;
    unique case (st_q)
      ST_IDLE: begin
        tmr_d = '0;
        pls_d = '0;
        if (expired) st_d = disc_en ? ST_WAIT : ST_FLAG;
      end
      ST_FLAG: begin
        tmr_d = '0;
        if (bus_high) st_d = ST_IDLE;
      end
      ST_WAIT: if (wait_done) begin
        st_d  = ST_CLK_LO;
        tmr_d = '0;
      end
      ST_CLK_LO: if (half_done) begin
        st_d  = ST_CLK_HI;
        tmr_d = '0;
      end
      ST_CLK_HI: if (half_done) begin
        pls_d = pls_q + 1'b1;
        tmr_d = '0;
        if (bus_high || (pls_q == PW'(MAX_PULSES - 1))) st_d = ST_STP_LO;
        else                                            st_d = ST_CLK_LO;
      end
      ST_STP_LO: if (half_done) begin
        st_d  = ST_STP_SH;
        tmr_d = '0;
      end
      ST_STP_SH: if (half_done) begin
        st_d  = ST_STP_REL;
        tmr_d = '0;
      end
      ST_STP_REL: if (half_done) begin
        st_d  = ST_SETTLE;
        tmr_d = '0;
      end
      ST_SETTLE: begin
        tmr_d = '0;
        if (bus_high) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        tmr_d = '0;
        if (reenable_seen) st_d = ST_IDLE;
      end
      default: begin
        st_d  = ST_IDLE;
        tmr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      pls_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      pls_q <= pls_d;
    end
  end

  assign idle          = (st_q == ST_IDLE);
  assign fault_n       = (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign disconnect    = !(st_q == ST_IDLE || st_q == ST_FLAG);
  assign scl_pull      = (st_q == ST_CLK_LO) || (st_q == ST_STP_LO);
  assign sda_pull      = (st_q == ST_STP_LO) || (st_q == ST_STP_SH);
  assign accel_inhibit = (st_q == ST_CLK_LO) || (st_q == ST_CLK_HI) ||
                         (st_q == ST_STP_LO) || (st_q == ST_STP_SH) ||
                         (st_q == ST_STP_REL);

  // R6: pulse count never exceeds the limit
  a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q <= PW'(MAX_PULSES));

  // R7: SDA is released only while SCL has been free for a cycle
  a_r7_stop_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> (!scl_pull && $past(!scl_pull)));

  // R8: any pull implies inhibited accelerators
  a_r8_inhibit_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull || sda_pull) |-> accel_inhibit);

  // R4: a fault without disconnect never drives the lines
  a_r4_flag_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !disconnect) |-> (!scl_pull && !sda_pull));

  // R9: disconnect drops only after a re-enable report
  a_r9_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disconnect) |-> $past(reenable_seen));

endmodule

// File: rtl/i2c_stuck_recovery.sv
module i2c_stuck_recovery #(
  parameter int unsigned TIMEOUT_CYC = 45000,
  parameter int unsigned WAIT_CYC    = 40,
  parameter int unsigned HALF_CYC    = 91,
  parameter int unsigned MAX_PULSES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic disc_en,
  input  logic chan_active,
  input  logic reenable_seen,
  output logic fault_n,
  output logic disconnect,
  output logic scl_pull,
  output logic sda_pull,
  output logic accel_inhibit
);

  logic [1:0] line_s;
  logic       bus_high;
  logic       expired;
  logic       idle;

  i2c_rcv_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (line_s)
  );

  assign bus_high = &line_s;

  i2c_rcv_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (idle),
    .chan_active (chan_active),
    .bus_high    (bus_high),
    .expired     (expired)
  );

  i2c_rcv_seq #(
    .WAIT_CYC   (WAIT_CYC),
    .HALF_CYC   (HALF_CYC),
    .MAX_PULSES (MAX_PULSES)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .expired       (expired),
    .bus_high      (bus_high),
    .disc_en       (disc_en),
    .reenable_seen (reenable_seen),
    .idle          (idle),
    .fault_n       (fault_n),
    .disconnect    (disconnect),
    .scl_pull      (scl_pull),
    .sda_pull      (sda_pull),
    .accel_inhibit (accel_inhibit)
  );

  // R5: a strap-high fault always comes with a disconnect request
  a_r5_disc_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fault_n) && disc_en) |-> disconnect);

endmodule

// File: tb/tb_i2c_stuck_recovery.sv
module tb_i2c_stuck_recovery;

  localparam int unsigned T_TO  = 20;
  localparam int unsigned T_WT  = 5;
  localparam int unsigned T_HF  = 4;
  localparam int unsigned T_MAX = 16;

  logic clk, rst_n, disc_en, chan_active, reenable_seen;
  logic dev_scl_low, dev_sda_low;
  logic fault_n, disconnect, scl_pull, sda_pull, accel_inhibit;
  logic scl_in, sda_in;
  int   checks, fails;

  assign scl_in = ~scl_pull & ~dev_scl_low;
  assign sda_in = ~sda_pull & ~dev_sda_low;

  i2c_stuck_recovery #(
    .TIMEOUT_CYC(T_TO), .WAIT_CYC(T_WT), .HALF_CYC(T_HF), .MAX_PULSES(T_MAX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .disc_en(disc_en), .chan_active(chan_active), .reenable_seen(reenable_seen),
    .fault_n(fault_n), .disconnect(disconnect), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .accel_inhibit(accel_inhibit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_pulses(input int k);
    return (k > int'(T_MAX)) ? int'(T_MAX) : k;
  endfunction

  function automatic int exp_fault_lat();
    return int'(T_TO) + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic measure_fault(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (fault_n && n < 1000);
  endtask

  task automatic bus_idle();
    dev_scl_low = 1'b0;
    dev_sda_low = 1'b0;
    repeat (4) tick();
  endtask

  task automatic run_trial(input bit disc, input int k, input bit use_scl);
    int n, pulses, hi_len, first, cyc;
    bit prev_scl, prev_sda, stop_ok, stop_seen, inh_bad, len_bad;
    disc_en = disc;
    chan_active = 1'b1;
    bus_idle();
    if (use_scl) dev_scl_low = 1'b1; else dev_sda_low = 1'b1;
    measure_fault(n);
    check(n == exp_fault_lat(), "R1 fault latency", n, exp_fault_lat());
    if (!disc) begin
      bit drove = 1'b0;
      for (int i = 0; i < 120; i++) begin
        tick();
        if (disconnect || scl_pull || sda_pull) drove = 1'b1;
      end
      check(!drove && !fault_n, "R4 flag only", drove, 0);
      bus_idle();
      check(fault_n == 1'b1, "R4 flag release", fault_n, 1);
      return;
    end
    check(disconnect == 1'b1, "R5 disconnect with fault", disconnect, 1);
    pulses = 0; hi_len = 0; first = -1; cyc = 0;
    prev_scl = 1'b0; prev_sda = 1'b0;
    stop_ok = 1'b0; stop_seen = 1'b0; inh_bad = 1'b0; len_bad = 1'b0;
    while (!fault_n && cyc < 3000) begin
      tick();
      cyc++;
      if (scl_pull && !prev_scl && !sda_pull) begin
        pulses++;
        if (first < 0) first = cyc;
      end
      if (scl_pull && !sda_pull) hi_len++;
      if (!scl_pull && prev_scl && !prev_sda && hi_len != int'(T_HF)) len_bad = 1'b1;
      if (!scl_pull) hi_len = 0;
      if (!sda_pull && prev_sda) begin
        stop_seen = 1'b1;
        stop_ok = !scl_pull && !prev_scl;
      end
      if ((scl_pull || sda_pull) && !accel_inhibit) inh_bad = 1'b1;
      if ((k <= int'(T_MAX) && pulses >= k) || stop_seen) begin
        dev_scl_low = 1'b0;
        dev_sda_low = 1'b0;
      end
      prev_scl = scl_pull;
      prev_sda = sda_pull;
    end
    check(first == int'(T_WT), "R5 wait before clocking", first, T_WT);
    check(pulses == exp_pulses(k), "R6 pulse count", pulses, exp_pulses(k));
    check(!len_bad, "R6 half period", len_bad, 0);
    check(stop_seen && stop_ok, "R7 stop order", stop_ok, 1);
    check(!inh_bad, "R8 inhibit during pulls", inh_bad, 0);
    check(fault_n == 1'b1, "R9 fault released", fault_n, 1);
    repeat (10) tick();
    check(disconnect == 1'b1, "R9 disconnect held", disconnect, 1);
    reenable_seen = 1'b1;
    tick();
    reenable_seen = 1'b0;
    check(disconnect == 1'b0, "R9 disconnect dropped", disconnect, 0);
  endtask

  initial begin
    int n;
    int unsigned seed;
    checks = 0; fails = 0;
    rst_n = 1'b0; disc_en = 1'b0; chan_active = 1'b0; reenable_seen = 1'b0;
    dev_scl_low = 1'b0; dev_sda_low = 1'b0;
    seed = $urandom(32'd2718);
    repeat (3) tick();
    check(fault_n && !disconnect && !scl_pull && !sda_pull && !accel_inhibit,
          "R10 reset state", {fault_n, disconnect, scl_pull, sda_pull, accel_inhibit}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) tick();

    // R3: timer parked without an active channel
    dev_sda_low = 1'b1;
    begin
      bit fired = 1'b0;
      for (int i = 0; i < 3 * int'(T_TO); i++) begin
        tick();
        if (!fault_n) fired = 1'b1;
      end
      check(!fired, "R3 no channel no fault", fired, 0);
    end
    chan_active = 1'b1;
    measure_fault(n);
    check(n == int'(T_TO), "R3 start on channel", n, T_TO);
    bus_idle();

    // R2: a single-cycle idle blip restarts the count
    dev_sda_low = 1'b1;
    repeat (T_TO - 3) tick();
    check(fault_n == 1'b1, "R2 no early fault", fault_n, 1);
    dev_sda_low = 1'b0;
    tick();
    dev_sda_low = 1'b1;
    measure_fault(n);
    check(n == exp_fault_lat(), "R2 restart latency", n, exp_fault_lat());
    bus_idle();

    // directed corners
    run_trial(1'b0, 3, 1'b0);
    run_trial(1'b1, 1, 1'b0);
    run_trial(1'b1, 16, 1'b0);
    run_trial(1'b1, 40, 1'b1);
    run_trial(1'b1, 7, 1'b1);

    // random trials
    for (int t = 0; t < 10; t++) begin
      run_trial(1'($urandom_range(0, 3) != 0), int'($urandom_range(1, 20)),
                1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule